// File: doc/BRIEF.md
# Serial SAR-ADC Frame Controller

This block is the host-side master for an eight-input successive-approximation converter that is reached over a four-wire serial link. A conversion frame starts when chip-select goes low, which also samples the analog input. The serial clock then runs for exactly sixteen periods. During those periods the converter uses the clock to resolve its sample. It also latches a 16-bit control word from the data-in line and returns its 16-bit result on the data-out line. Because there is no pipeline delay, the result read in a frame belongs to that same frame's sample.

A user asserts `start_i` while the block is idle and supplies the control word on `ctrl_word_i`. The block copies the word into a shadow register, runs the frame, and waits out the quiet interval with chip-select high. It then pulses `res_valid_o` for one cycle with the received word on `result_o`. The serial-clock half period and the setup, hold, quiet and power-up intervals are parameters counted in system-clock cycles. A pulse on `wake_i` tells the block that the converter has been powered down. The next frame is then preceded by a power-up wait.

The state machine has seven states. ST_IDLE waits for a start. ST_WAKE holds chip-select high through the power-up wait. ST_SETUP drives chip-select low with the serial clock high. ST_SCLK_LO and ST_SCLK_HI form each clock period. ST_HOLD keeps chip-select low after the last falling edge. ST_QUIET raises chip-select for the quiet time.

The transitions are as follows. ST_IDLE goes to ST_WAKE on a start with a wake pending, and to ST_SETUP on a start without one. ST_WAKE goes to ST_SETUP and ST_SETUP goes to ST_SCLK_LO when their timers expire. ST_SCLK_LO goes to ST_SCLK_HI after each of the first fifteen low phases, and to ST_HOLD after the sixteenth. ST_SCLK_HI returns to ST_SCLK_LO. ST_HOLD goes to ST_QUIET, and ST_QUIET returns to ST_IDLE with the valid pulse.

Top module: `adc_frame_ctrl`

## Requirements
- R1: Out of reset, cs_n_o=1, sclk_o=1, din_o=0, busy_o=0, res_valid_o=0 and result_o=0.
- R2: A start in idle is taken at the next clock edge, where cs_n_o falls and busy_o rises together. The control word is copied at that edge. A start or a new control word presented while busy has no effect on the running frame.
- R3: After chip-select falls, sclk_o stays high for SETUP_CYC cycles before its first falling edge.
- R4: Each frame has exactly 16 serial-clock periods. Each low phase lasts HALF_CYC cycles, and each of the first fifteen high phases lasts HALF_CYC cycles. sclk_o is high whenever cs_n_o is high.
- R5: The control word leaves on din_o MSB first. Bit 15 is present from the chip-select fall, and each following bit changes on a rising edge, so every bit is stable across the falling edge on which the converter latches it. din_o is 0 after a completed frame.
- R6: dout_i is sampled at the end of each low phase, on the rising edge after each falling edge. The first sample is bit 15 of result_o and the sixteenth is bit 0.
- R7: sclk_o returns high HALF_CYC cycles after the sixteenth falling edge, and cs_n_o rises HOLD_CYC cycles after that.
- R8: cs_n_o stays high for QUIET_CYC cycles after rising, and busy_o stays high during that time. Only then does the block go idle, so the next chip-select fall cannot come sooner.
- R9: res_valid_o is a one-cycle pulse, and it coincides with busy_o falling. result_o holds the received word from that pulse until the next pulse.
- R10: A wake_i pulse marks a power-up as pending. The next frame taken is preceded by PWRUP_CYC cycles with busy_o high and cs_n_o high. The pending mark is used once.
- R11: At the system clock period, each serial-clock phase inside a frame lasts at least 20 ns, the setup at least 10 ns, the chip-select low time after the last falling edge at least 20 ns, and the quiet time at least 50 ns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Frame request, taken only when idle |
| ctrl_word_i | input | 16 | Control word to shift out in the frame |
| wake_i | input | 1 | Converter was powered down; insert power-up wait |
| dout_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low chip-select |
| sclk_o | output | 1 | Serial clock, idle high |
| din_o | output | 1 | Serial data to the converter |
| busy_o | output | 1 | Frame in progress |
| res_valid_o | output | 1 | One-cycle result strobe |
| result_o | output | 16 | Word received in the last frame |

## Verification
The assertions measure real durations on every cycle. They check the length of each serial-clock phase, the setup before the first falling edge, the chip-select low time after the sixteenth falling edge, and the quiet time before the next fall, each against its nanosecond minimum. They also count sixteen falling edges per frame, check that the clock is high while chip-select is high, and check that the valid strobe is a single idle-cycle pulse.

Only the bench's scenarios can show the data path and the wake handling. For the data path, the bench checks the bit order on both lines, the copy of the control word at start, and that the result belongs to the frame that produced it. For wake handling, it checks that the power-up wait is inserted only once after a wake pulse, and that starts issued mid-frame are ignored.

// File: rtl/adc_fc_pkg.sv
package adc_fc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAKE,
        ST_SETUP,
        ST_SCLK_LO,
        ST_SCLK_HI,
        ST_HOLD,
        ST_QUIET
    } fc_state_e;

    function automatic int fc_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/adc_fc_timer.sv
module adc_fc_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire = (cnt_q == '0);
endmodule

// File: rtl/adc_fc_txsr.sv
module adc_fc_txsr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    output logic         ser_o
);
    logic [W-1:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (load) begin
            sr_q <= load_val;
        end else if (shift) begin
            sr_q <= {sr_q[W-2:0], 1'b0};
        end
    end

    assign ser_o = sr_q[W-1];
endmodule

// File: rtl/adc_fc_rxsr.sv
module adc_fc_rxsr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         shift,
    input  logic         ser_i,
    output logic [W-1:0] par_o
);
    logic [W-1:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (clear) begin
            sr_q <= '0;
        end else if (shift) begin
            sr_q <= {sr_q[W-2:0], ser_i};
        end
    end

    assign par_o = sr_q;
endmodule

// File: rtl/adc_fc_wake.sv
module adc_fc_wake (
    input  logic clk,
    input  logic rst_n,
    input  logic wake_i,
    input  logic accept,
    output logic use_o
);
    logic pend_q;

    assign use_o = pend_q | wake_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else begin
            pend_q <= accept ? 1'b0 : use_o;
        end
    end
endmodule

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl
    import adc_fc_pkg::*;
#(
    parameter int WORD_W    = 16,
    parameter int HALF_CYC  = 3,
    parameter int SETUP_CYC = 1,
    parameter int HOLD_CYC  = 2,
    parameter int QUIET_CYC = 5,
    parameter int PWRUP_CYC = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [WORD_W-1:0] ctrl_word_i,
    input  logic              wake_i,
    input  logic              dout_i,
    output logic              cs_n_o,
    output logic              sclk_o,
    output logic              din_o,
    output logic              busy_o,
    output logic              res_valid_o,
    output logic [WORD_W-1:0] result_o
);
    localparam int MAX_DUR = fc_max(fc_max(fc_max(HALF_CYC, SETUP_CYC),
                                           fc_max(HOLD_CYC, QUIET_CYC)),
                                    PWRUP_CYC);
    localparam int CNT_W = $clog2(MAX_DUR + 1);
    localparam int BIT_W = $clog2(WORD_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

    fc_state_e state_q, state_d;

    logic              expire;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              wake_use;
    logic              accept;
    logic              bit_shift;
    logic              frame_end;
    logic [BIT_W-1:0]  bit_q;
    logic [WORD_W-1:0] rx_word;
    logic [WORD_W-1:0] result_q;
    logic              cs_n_q, sclk_q, busy_q, valid_q;

    assign accept    = (state_q == ST_IDLE) && start_i;
    assign bit_shift = (state_q == ST_SCLK_LO) && expire;
    assign frame_end = (state_q == ST_QUIET) && expire;
    assign tmr_load  = (state_d != state_q);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_i) state_d = wake_use ? ST_WAKE : ST_SETUP;
            ST_WAKE:    if (expire)  state_d = ST_SETUP;
            ST_SETUP:   if (expire)  state_d = ST_SCLK_LO;
            ST_SCLK_LO: if (expire)  state_d = (bit_q == LAST_BIT) ? ST_HOLD : ST_SCLK_HI;
            ST_SCLK_HI: if (expire)  state_d = ST_SCLK_LO;
            ST_HOLD:    if (expire)  state_d = ST_QUIET;
            ST_QUIET:   if (expire)  state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    // Duration of the state being entered, minus one
    always_comb begin
        case (state_d)
            ST_WAKE:    tmr_val = CNT_W'(PWRUP_CYC - 1);
            ST_SETUP:   tmr_val = CNT_W'(SETUP_CYC - 1);
            ST_SCLK_LO: tmr_val = CNT_W'(HALF_CYC - 1);
            ST_SCLK_HI: tmr_val = CNT_W'(HALF_CYC - 1);
            ST_HOLD:    tmr_val = CNT_W'(HOLD_CYC - 1);
            ST_QUIET:   tmr_val = CNT_W'(QUIET_CYC - 1);
            default:    tmr_val = '0;
        endcase
    end

    // Registered outputs, decoded from the state being entered
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n_q  <= 1'b1;
            sclk_q  <= 1'b1;
            busy_q  <= 1'b0;
            valid_q <= 1'b0;
        end else begin
            cs_n_q  <= !(state_d inside {ST_SETUP, ST_SCLK_LO, ST_SCLK_HI, ST_HOLD});
            sclk_q  <= (state_d != ST_SCLK_LO);
            busy_q  <= (state_d != ST_IDLE);
            valid_q <= frame_end;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q <= '0;
        end else if (accept) begin
            bit_q <= '0;
        end else if (bit_shift) begin
            bit_q <= bit_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_q <= '0;
        end else if (frame_end) begin
            result_q <= rx_word;
        end
    end

    adc_fc_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expire   (expire)
    );

    adc_fc_txsr #(.W(WORD_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (ctrl_word_i),
        .shift    (bit_shift),
        .ser_o    (din_o)
    );

    adc_fc_rxsr #(.W(WORD_W)) u_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (accept),
        .shift (bit_shift),
        .ser_i (dout_i),
        .par_o (rx_word)
    );

    adc_fc_wake u_wake (
        .clk    (clk),
        .rst_n  (rst_n),
        .wake_i (wake_i),
        .accept (accept),
        .use_o  (wake_use)
    );

    assign cs_n_o      = cs_n_q;
    assign sclk_o      = sclk_q;
    assign busy_o      = busy_q;
    assign res_valid_o = valid_q;
    assign result_o    = result_q;
endmodule

// File: rtl/adc_frame_ctrl_chk.sv
module adc_frame_ctrl_chk #(
    parameter int CLK_NS = 10
) (
    input logic clk,
    input logic rst_n,
    input logic cs_n_o,
    input logic sclk_o,
    input logic busy_o,
    input logic res_valid_o
);
    localparam int MIN_PHASE_NS = 20;
    localparam int MIN_SETUP_NS = 10;
    localparam int MIN_HOLD_NS  = 20;
    localparam int MIN_QUIET_NS = 50;

    logic sclk_d;
    int unsigned lo_run, hi_run, cs_lo_run, cs_hi_run, since_fall, fall_cnt;
    logic fell_now;

    assign fell_now = sclk_d && !sclk_o;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d     <= 1'b1;
            lo_run     <= 0;
            hi_run     <= 0;
            cs_lo_run  <= 0;
            cs_hi_run  <= 1000;
            since_fall <= 1000;
            fall_cnt   <= 0;
        end else begin
            sclk_d     <= sclk_o;
            lo_run     <= sclk_o ? 0 : lo_run + 1;
            hi_run     <= sclk_o ? hi_run + 1 : 0;
            cs_lo_run  <= cs_n_o ? 0 : cs_lo_run + 1;
            cs_hi_run  <= cs_n_o ? ((cs_hi_run < 1000) ? cs_hi_run + 1 : cs_hi_run) : 0;
            since_fall <= fell_now ? 1 : ((since_fall < 1000) ? since_fall + 1 : since_fall);
            fall_cnt   <= cs_n_o ? 0 : fall_cnt + (fell_now ? 1 : 0);
        end
    end

    p_idle_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> sclk_o);

    p_sixteen_falls_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n_o) |-> fall_cnt == 16);

    p_low_phase_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_o) |-> lo_run * CLK_NS >= MIN_PHASE_NS);

    p_high_phase_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sclk_o) && fall_cnt != 0) |-> hi_run * CLK_NS >= MIN_PHASE_NS);

    p_cs_setup_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sclk_o) && fall_cnt == 0) |-> cs_lo_run * CLK_NS >= MIN_SETUP_NS);

    p_cs_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n_o) |-> since_fall * CLK_NS >= MIN_HOLD_NS);

    p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_o) |-> cs_hi_run * CLK_NS >= MIN_QUIET_NS);

    p_busy_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n_o |-> busy_o);

    p_valid_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |=> !res_valid_o);

    p_valid_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> (cs_n_o && !busy_o));
endmodule

bind adc_frame_ctrl adc_frame_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n_o      (cs_n_o),
    .sclk_o      (sclk_o),
    .busy_o      (busy_o),
    .res_valid_o (res_valid_o)
);

// File: tb/tb_adc_frame_ctrl.sv
`timescale 1ns/1ps
module tb_adc_frame_ctrl;
    localparam int H  = 3;
    localparam int S  = 1;
    localparam int D  = 2;
    localparam int Q  = 5;
    localparam int PW = 100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] ctrl_word_i = '0;
    logic        wake_i = 1'b0;
    logic        dout_i = 1'b0;
    logic        cs_n_o, sclk_o, din_o, busy_o, res_valid_o;
    logic [15:0] result_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    adc_frame_ctrl #(
        .WORD_W(16), .HALF_CYC(H), .SETUP_CYC(S),
        .HOLD_CYC(D), .QUIET_CYC(Q), .PWRUP_CYC(PW)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .ctrl_word_i(ctrl_word_i),
        .wake_i(wake_i), .dout_i(dout_i), .cs_n_o(cs_n_o), .sclk_o(sclk_o),
        .din_o(din_o), .busy_o(busy_o), .res_valid_o(res_valid_o), .result_o(result_o)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Converter model on the serial side
    logic [15:0] resp_word = '0;
    logic [15:0] slv_din = '0;
    int          slv_cnt = 0;

    always @(negedge cs_n_o) slv_cnt = 0;
    always @(posedge cs_n_o) dout_i = 1'b0;
    always @(negedge sclk_o) begin
        if (!cs_n_o && slv_cnt < 16) begin
            slv_din = {slv_din[14:0], din_o};
            dout_i  = resp_word[15 - slv_cnt];
            slv_cnt = slv_cnt + 1;
        end
    end

    // Cycle reference model
    int          m_e = -1;
    int          m_wc = 0;
    bit          m_pend = 0;
    logic [15:0] m_ctrl = '0, m_resp = '0, m_result = '0;

    function automatic int total_len(input int wc);
        return wc + S + 31 * H + D + Q;
    endfunction

    always @(posedge clk) begin
        bit idle, acc, wu;
        if (!rst_n) begin
            m_e = -1; m_pend = 0; m_result = '0;
        end else begin
            idle = (m_e < 0) || (m_e == total_len(m_wc));
            acc  = idle && start_i;
            wu   = m_pend || wake_i;
            if (acc) begin
                m_e = 0; m_wc = wu ? PW : 0;
                m_ctrl = ctrl_word_i; m_resp = resp_word;
            end else if (m_e >= 0 && m_e == total_len(m_wc)) begin
                m_e = -1;
            end else if (m_e >= 0) begin
                m_e = m_e + 1;
                if (m_e == total_len(m_wc)) m_result = m_resp;
            end
            m_pend = acc ? 1'b0 : wu;
        end
    end

    always @(negedge clk) begin
        int off, u, p, r;
        logic e_cs, e_sclk, e_din, e_busy, e_val;
        string tag;
        if (rst_n && !finished) begin
            e_cs = 1; e_sclk = 1; e_din = 0; e_busy = 0; e_val = 0; tag = "R2";
            if (m_e >= 0 && m_e < total_len(m_wc)) begin
                e_busy = 1;
                off = m_e - m_wc;
                if (m_e < m_wc) begin
                    tag = "R10"; e_din = m_ctrl[15];
                end else if (off < S) begin
                    tag = "R3"; e_cs = 0; e_din = m_ctrl[15];
                end else begin
                    u = off - S;
                    if (u < 31 * H) begin
                        tag = "R4"; e_cs = 0;
                        p = u / (2 * H); r = u % (2 * H);
                        e_sclk = (r >= H);
                        e_din  = (r < H) ? m_ctrl[15 - p] : m_ctrl[14 - p];
                    end else if (u < 31 * H + D) begin
                        tag = "R7"; e_cs = 0;
                    end else begin
                        tag = "R8";
                    end
                end
            end else if (m_e >= 0) begin
                e_val = 1; tag = "R9";
            end
            check(tag, "cs_n_o", cs_n_o, e_cs);
            check(tag, "sclk_o", sclk_o, e_sclk);
            check("R5", "din_o", din_o, e_din);
            check("R2", "busy_o", busy_o, e_busy);
            check("R9", "res_valid_o", res_valid_o, e_val);
            check("R6", "result_o", result_o, m_result);
        end
    end

    // Phase-length measurement in ns
    int lo_cnt = 0;
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (!sclk_o) lo_cnt = lo_cnt + 1;
            else if (lo_cnt != 0) begin
                checks++;
                if (lo_cnt * 10 < 20) begin
                    errors++;
                    $display("FAIL R11 low phase ns actual=%0d expected>=20", lo_cnt * 10);
                end
                lo_cnt = 0;
            end
        end
    end

    task automatic wait_valid();
        do @(negedge clk); while (!res_valid_o);
    endtask

    task automatic frame(input logic [15:0] cw, input logic [15:0] rw);
        @(negedge clk);
        resp_word = rw; ctrl_word_i = cw; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_valid();
        check("R5", "word seen by converter", slv_din, cw);
        check("R6", "result word", result_o, rw);
    endtask

    initial begin
        int t0;
        repeat (3) @(negedge clk);
        check("R1", "cs_n_o reset", cs_n_o, 1);
        check("R1", "sclk_o reset", sclk_o, 1);
        check("R1", "din_o reset", din_o, 0);
        check("R1", "busy_o reset", busy_o, 0);
        check("R1", "res_valid_o reset", res_valid_o, 0);
        check("R1", "result_o reset", result_o, 0);
        rst_n = 1'b1;

        frame(16'hA5C3, 16'h1234);
        frame(16'h8001, 16'hFFFF);

        // back-to-back: start held high across the idle cycle
        @(negedge clk);
        resp_word = 16'h0000; ctrl_word_i = 16'hFFFF; start_i = 1'b1;
        wait_valid();
        check("R6", "first back-to-back result", result_o, 16'h0000);
        resp_word = 16'h5A5A;
        @(negedge clk);
        start_i = 1'b0;
        check("R2", "busy after held start", busy_o, 1);
        wait_valid();
        check("R6", "second back-to-back result", result_o, 16'h5A5A);
        check("R9", "result held after pulse", result_o, 16'h5A5A);

        // wake, then mid-frame start and word change are ignored
        @(negedge clk);
        wake_i = 1'b1;
        @(negedge clk);
        wake_i = 1'b0;
        resp_word = 16'hC0DE; ctrl_word_i = 16'h0F0F; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        t0 = 0;
        while (cs_n_o) begin t0++; @(negedge clk); end
        check("R10", "power-up wait cycles", t0, PW);
        repeat (20) @(negedge clk);
        start_i = 1'b1; ctrl_word_i = 16'hFFFF;
        @(negedge clk);
        start_i = 1'b0;
        wait_valid();
        check("R2", "word unchanged by mid-frame write", slv_din, 16'h0F0F);
        check("R6", "result after wake", result_o, 16'hC0DE);

        // wake consumed once: next frame has no wait
        @(negedge clk);
        resp_word = 16'h8001; ctrl_word_i = 16'h0001; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check("R10", "no second power-up wait", cs_n_o, 0);
        wait_valid();
        check("R6", "final result", result_o, 16'h8001);
        repeat (4) @(negedge clk);
        check("R5", "din_o idle after frame", din_o, 0);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule